// File: doc/BRIEF.md
# Edge-Triggered Digital Monostable

The block produces one output pulse of programmable length each time a rising edge appears on an asynchronous trigger input, for example a periodic signal from a microcontroller. The trigger is brought into the clock domain by a shift-register synchroniser. A one-cycle strobe is then derived from its rising edge. That strobe raises a busy flag and, in the same cycle, loads a down-counter from the parallel width input. The busy flag is the pulse output, and it also enables the counter.

The counter is one bit wider than the width input. Its top bit acts as the end-of-count flag, so no magnitude comparator is needed. When that bit sets, the busy flag drops and the counter freezes. Nothing then moves until the next rising trigger edge. The repetition rate comes entirely from the trigger source.

Top module: `pulse_mono`

## Requirements
- R1: While `rstN` is low, and after its release until the first trigger edge, `pulseOut` is 0.
- R2: With a nonzero width, a rising edge on `trigIn` (held high for at least two clock periods) makes `pulseOut` go high at the (SYNC_STAGES+1)-th rising clock edge after the trigger rises. With the default SYNC_STAGES=2 this is the third edge.
- R3: `pulseOut` stays high for exactly `widthIn` clock cycles, for any width from 1 to 2^WIDTH_BITS-1. It then returns to 0.
- R4: A rising trigger edge while `widthIn` is 0 produces no pulse.
- R5: A rising trigger edge that arrives while `pulseOut` is high is ignored. The pulse in progress is neither restarted nor lengthened, and no second pulse follows it.
- R6: `widthIn` is sampled only when a pulse starts. Changing it while a pulse is high does not alter that pulse's length.
- R7: A trigger that stays high produces exactly one pulse. A new pulse requires a new low-to-high transition.
- R8: Once a pulse ends, the counter holds and the block stays idle. The next rising trigger edge starts a new pulse with the same latency and length rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | 1 | Asynchronous trigger; a rising edge starts a pulse |
| widthIn | input | WIDTH_BITS | Pulse length in clock cycles; 0 suppresses the pulse |
| pulseOut | output | 1 | Registered pulse output |

## Verification
The bench builds the block with its defaults, WIDTH_BITS=8 and SYNC_STAGES=2. With these values the full width range is short enough to run end to end. This brings the two extremes within reach: the one-cycle pulse, where the loaded value is already negative, and the 255-cycle pulse, where the counter's top bit is only reached after the whole unsigned range has been used. The two-stage synchroniser fixes the trigger-to-pulse latency at three edges. That lets the bench check a retrigger at a known cycle inside a running pulse, and a width change at a known cycle inside a running pulse.

// File: rtl/pm_pkg.sv
package pm_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture width and start counting
    logic run;    // busy flag: counter enable and pulse output
  } pmCmd_t;

  // Status from datapath to control
  typedef struct packed {
    logic termCnt;    // counter top bit: end of count reached
    logic widthZero;  // programmed width is zero
  } pmStat_t;

endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    trigIn,
  input  pmStat_t stat,
  output pmCmd_t  cmd
);

  localparam int SYNC_LAST = SYNC_STAGES - 1;

  logic [SYNC_LAST:0] syncReg;
  logic               trigPrev;
  logic               edgeStrobe;
  logic               runFlag;
  logic               loadNow;

  // Synchroniser shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg  <= '0;
      trigPrev <= 1'b0;
    end else begin
      syncReg  <= {syncReg[SYNC_LAST-1:0], trigIn};
      trigPrev <= syncReg[SYNC_LAST];
    end
  end

  assign edgeStrobe = syncReg[SYNC_LAST] & ~trigPrev;

  // Edges while busy or with zero width are dropped
  assign loadNow = edgeStrobe & ~runFlag & ~stat.widthZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runFlag <= 1'b0;
    end else if (loadNow) begin
      runFlag <= 1'b1;
    end else if (runFlag && stat.termCnt) begin
      runFlag <= 1'b0;
    end
  end

  assign cmd.load = loadNow;
  assign cmd.run  = runFlag;

  // A pulse only ends once the datapath reports end of count
  AST_END_AT_TERMINAL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runFlag) |-> $past(stat.termCnt)); // R3

  // Busy flag never rises without a detected edge
  AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runFlag) |-> $past(edgeStrobe)); // R2

  // A zero width never starts a pulse
  AST_ZERO_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (edgeStrobe && !runFlag && stat.widthZero) |=> !runFlag); // R4

  // An edge during a pulse cannot extend it past the terminal count
  AST_BUSY_IGNORES_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (runFlag && stat.termCnt && edgeStrobe) |=> !runFlag); // R5

endmodule

// File: rtl/pm_dpath.sv
module pm_dpath
  import pm_pkg::*;
#(
  parameter int WIDTH_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [WIDTH_BITS-1:0] widthIn,
  input  pmCmd_t                cmd,
  output pmStat_t               stat
);

  localparam int CNT_W = WIDTH_BITS + 1;
  localparam int MSB   = CNT_W - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  // Load width-2: counting through zero into the sign bit gives width high cycles
  assign loadVal = {1'b0, widthIn} - CNT_W'(2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '1;
    end else if (cmd.load) begin
      cnt <= loadVal;
    end else if (cmd.run && !cnt[MSB]) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign stat.termCnt   = cnt[MSB];
  assign stat.widthZero = (widthIn == '0);

  // While busy and not terminal the counter steps down by one
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && !cmd.load && !cnt[MSB]) |=> (cnt == $past(cnt) - CNT_W'(1))); // R3

  // Idle: counter frozen at its terminal value
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.load) |=> $stable(cnt)); // R8

  AST_IDLE_TERMINAL: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.run |-> cnt[MSB]); // R8

  // Width input only matters on a load
  AST_WIDTH_SAMPLED_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && !cmd.load && !cnt[MSB]) |=> !cnt[MSB] || ($past(cnt) == '0)); // R6

endmodule

// File: rtl/pulse_mono.sv
module pulse_mono
  import pm_pkg::*;
#(
  parameter int WIDTH_BITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  trigIn,
  input  logic [WIDTH_BITS-1:0] widthIn,
  output logic                  pulseOut
);

  pmCmd_t  cmd;
  pmStat_t stat;

  pm_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .trigIn (trigIn),
    .stat   (stat),
    .cmd    (cmd)
  );

  pm_dpath #(.WIDTH_BITS(WIDTH_BITS)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .widthIn (widthIn),
    .cmd     (cmd),
    .stat    (stat)
  );

  assign pulseOut = cmd.run;

  // Pulse is low whenever reset has just been applied
  AST_RESET_LOW: assert property (@(posedge clk)
    !rstN |=> !pulseOut); // R1

endmodule

// File: tb/pulse_mono_test.sv
module pulse_mono_test;

  localparam int WB = 8;
  localparam int SS = 2;
  localparam int LAT = SS + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          trigIn = 1'b0;
  logic [WB-1:0] widthIn = '0;
  logic          pulseOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pulse_mono #(.WIDTH_BITS(WB), .SYNC_STAGES(SS)) uut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .widthIn(widthIn), .pulseOut(pulseOut)
  );

  always #2 clk = ~clk;

  // Stimulus table: width and expected high length (R3, R8: back-to-back shots)
  localparam int VEC_N = 7;
  localparam int VEC_W[VEC_N]   = '{1, 2, 3, 5, 17, 128, 255};
  localparam int VEC_LEN[VEC_N] = '{1, 2, 3, 5, 17, 128, 255};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One trigger shot; returns first-high sample index, high count, rising transitions
  task automatic shot(input int w, input int win, input int retrigAt, input int newWidthAt,
                      input int newWidth, input bit holdHigh,
                      output int first, output int len, output int rises);
    bit prev = 0;
    first = -1; len = 0; rises = 0;
    widthIn = WB'(w);
    trigIn = 1'b1;
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      if (pulseOut && first < 0) first = i;
      if (pulseOut) len++;
      if (pulseOut && !prev) rises++;
      prev = pulseOut;
      if (i == 2 && !holdHigh) trigIn = 1'b0;
      if (i == retrigAt) trigIn = 1'b1;
      if (i == retrigAt + 2) trigIn = 1'b0;
      if (i == newWidthAt) widthIn = WB'(newWidth);
    end
  endtask

  initial begin
    int f, l, r;
    // R1: reset state
    @(negedge clk);
    check(pulseOut == 1'b0, "R1 during reset", pulseOut, 0);
    widthIn = 8'd4;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(pulseOut == 1'b0, "R1 after reset", pulseOut, 0);

    // Table walk: R2 latency, R3 length, R8 repeated shots
    for (int k = 0; k < VEC_N; k++) begin
      shot(VEC_W[k], VEC_W[k] + 12, -10, -10, 0, 0, f, l, r);
      check(f == LAT, "R2 latency", f, LAT);
      check(l == VEC_LEN[k], "R3 length", l, VEC_LEN[k]);
      check(r == 1, "R8 single pulse per edge", r, 1);
    end

    // R4: zero width
    shot(0, 20, -10, -10, 0, 0, f, l, r);
    check(l == 0, "R4 zero width", l, 0);

    // R5: retrigger in the middle of a 10-cycle pulse
    shot(10, 30, 5, -10, 0, 0, f, l, r);
    check(l == 10, "R5 retrigger length", l, 10);
    check(r == 1, "R5 retrigger count", r, 1);

    // R5: retrigger edge landing on the last high cycle (strobe at sample 10)
    shot(8, 30, 8, -10, 0, 0, f, l, r);
    check(l == 8 && r == 1, "R5 retrigger at end", l, 8);

    // R6: width changed mid-pulse
    shot(6, 30, -10, 4, 20, 0, f, l, r);
    check(l == 6, "R6 width change", l, 6);

    // R7: trigger held high
    shot(4, 40, -10, -10, 0, 1, f, l, r);
    check(l == 4 && r == 1, "R7 level held", l, 4);
    trigIn = 1'b0;
    repeat (4) @(negedge clk);

    // R8: after idle, a new edge works as before
    shot(7, 20, -10, -10, 0, 0, f, l, r);
    check(f == LAT && l == 7, "R8 retrigger after idle", l, 7);

    // R1: reset in the middle of a pulse
    widthIn = 8'd50;
    trigIn = 1'b1;
    repeat (10) @(negedge clk);
    trigIn = 1'b0;
    rstN = 1'b0;
    #1;
    check(pulseOut == 1'b0, "R1 reset mid-pulse", pulseOut, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (60) @(negedge clk);
    check(pulseOut == 1'b0, "R1 idle after reset", pulseOut, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule